// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software run management transactions against external Ethernet PHYs over a two-wire clock/data management bus. Software talks to it through four 16-bit registers. It picks the framing (Clause 22 or Clause 45) in a configuration register and loads a port and register (or device) number into a control register. It then starts an operation by writing the control, address or data register. While a frame is on the wire the block reports busy, and it refuses further register writes until the frame has finished.

The block divides the system clock down to the management clock. It shifts out a 32-bit preamble, the start, opcode, port, register/device, turnaround and data fields, and releases the data pin during the turnaround and data phase of a read. It captures the 16 bits a PHY returns. It raises a read-error flag when no PHY pulls the second turnaround bit low. In Clause 45 mode the access is split: a write to the address register sends an address frame, and a later data write or read-request write performs the data phase.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the configuration register reads 0 (Clause 22, not busy, no error), the data pin enable is low and the management clock is low.
- R2: The management clock has a period of DIV system clocks with equal high and low halves. The data pin value and its enable change only when the management clock falls, and incoming data is sampled when it rises.
- R3: The registers are: address 0 configuration (bit 0 mode, 1 = Clause 45; bit 1 busy; bit 2 read error), address 1 control (bits [9:5] port, bits [4:0] register or device, bit 15 read request, not stored), address 2 Clause 45 register address, and address 3 data. Read data appears on the output one clock after the read strobe.
- R4: Every frame is 64 bits sent most significant bit first: 32 ones, then start (01 for Clause 22, 00 for Clause 45), a 2-bit opcode, the 5-bit port, the 5-bit register/device, 2 turnaround bits and 16 data bits.
- R5: In Clause 22 mode, a write to the data register sends a write frame (opcode 01, turnaround 10) carrying the written value to the port and register held in control.
- R6: A control write with bit 15 set starts a read frame (opcode 10 in Clause 22, 11 in Clause 45) to the port and register/device in that same write. The master releases the pin for the last 18 bits, and the 16 sampled data bits then read back from the data register.
- R7: The read-error flag is set when the second turnaround bit of a read is sampled as 1, and it is cleared when the next read starts.
- R8: In Clause 45 mode, a write to the address register sends an address frame (opcode 00, turnaround 10, the value as data). The same write in Clause 22 mode, or a control write with bit 15 clear, starts no frame.
- R9: In Clause 45 mode, a write to the data register sends a write frame with start 00 and opcode 01 to the port and device in control.
- R10: Busy sets at the clock edge that accepts the starting write and clears after the last bit period. Every register write that arrives while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data in from the pad |
| mdio_o | output | 1 | Management data out to the pad |
| mdio_oe | output | 1 | Management data output enable |

## Verification
A bit index that drifts shows up on the pins within one frame. The captured 64-bit stream then has a shifted field, or the pin is released at the wrong bit of a read, and the responder in the bench flags both. A stuck or early busy flag shows in the configuration read that follows the starting write, or in a frame count that is off after a write that should have been dropped. A wrong capture point shows in the data or error flag read back right after the frame ends.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [2:0] {
    XF_C22_WR,
    XF_C22_RD,
    XF_C45_AD,
    XF_C45_WR,
    XF_C45_RD
  } xfer_e;

  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;

  localparam logic [1:0] RA_CFG = 2'd0;
  localparam logic [1:0] RA_CTL = 2'd1;
  localparam logic [1:0] RA_ADR = 2'd2;
  localparam logic [1:0] RA_DAT = 2'd3;

  localparam int CTL_RD_BIT = 15;

  // Fields after the preamble: start, opcode, port, reg/dev, turnaround, data
  function automatic logic [31:0] frame_header(input xfer_e k, input logic [4:0] port,
                                               input logic [4:0] ra, input logic [15:0] pay);
    logic [31:0] h;
    case (k)
      XF_C22_WR: h = {2'b01, 2'b01, port, ra, 2'b10, pay};
      XF_C22_RD: h = {2'b01, 2'b10, port, ra, 2'b11, 16'hFFFF};
      XF_C45_AD: h = {2'b00, 2'b00, port, ra, 2'b10, pay};
      XF_C45_WR: h = {2'b00, 2'b01, port, ra, 2'b10, pay};
      default:   h = {2'b00, 2'b11, port, ra, 2'b11, 16'hFFFF};
    endcase
    return h;
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap     = (cnt_q == CW'(HALF - 1));
  assign fall_stb = wrap & mdc_q;
  assign rise_stb = wrap & ~mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  xfer_e       kind,
  input  logic [4:0]  port,
  input  logic [4:0]  regad,
  input  logic [15:0] payload,
  input  logic        fall_stb,
  input  logic        rise_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_data,
  output logic        rd_err
);
  localparam int IW = $clog2(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] sr_q;
  logic [IW-1:0]        idx_q;
  logic [IW-1:0]        idx_nx;
  logic                 started_q;
  logic                 is_rd_q;
  logic                 busy_q;
  logic                 mdo_q;
  logic                 oe_q;
  logic                 done_q;
  logic [15:0]          cap_q;
  logic                 err_q;

  assign idx_nx  = idx_q + 1'b1;
  assign busy    = busy_q;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
  assign rd_done = done_q;
  assign rd_data = cap_q;
  assign rd_err  = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= '0;
      idx_q     <= '0;
      started_q <= 1'b0;
      is_rd_q   <= 1'b0;
      busy_q    <= 1'b0;
      mdo_q     <= 1'b1;
      oe_q      <= 1'b0;
      done_q    <= 1'b0;
      cap_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q    <= 1'b1;
        started_q <= 1'b0;
        idx_q     <= '0;
        sr_q      <= {{PRE_LEN{1'b1}}, frame_header(kind, port, regad, payload)};
        is_rd_q   <= (kind == XF_C22_RD) || (kind == XF_C45_RD);
        if ((kind == XF_C22_RD) || (kind == XF_C45_RD)) err_q <= 1'b0;
      end else if (busy_q && fall_stb) begin
        if (!started_q) begin
          started_q <= 1'b1;
          mdo_q     <= sr_q[FRAME_LEN-1];
          sr_q      <= {sr_q[FRAME_LEN-2:0], 1'b1};
          oe_q      <= 1'b1;
        end else if (idx_q == IW'(FRAME_LEN - 1)) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          mdo_q  <= 1'b1;
          done_q <= is_rd_q;
        end else begin
          idx_q <= idx_nx;
          mdo_q <= sr_q[FRAME_LEN-1];
          sr_q  <= {sr_q[FRAME_LEN-2:0], 1'b1};
          oe_q  <= !(is_rd_q && (idx_nx >= IW'(TA_IDX)));
        end
      end else if (busy_q && rise_stb && started_q && is_rd_q) begin
        if (idx_q == IW'(TA_IDX + 1)) err_q <= mdio_i;
        if (idx_q >= IW'(DATA_IDX))   cap_q <= {cap_q[14:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        busy,
  input  logic        eng_done,
  input  logic [15:0] eng_data,
  input  logic        eng_err,
  output logic        start,
  output xfer_e       kind,
  output logic [4:0]  port,
  output logic [4:0]  regad,
  output logic [15:0] payload
);
  logic        mode_q;
  logic [4:0]  port_q;
  logic [4:0]  ra_q;
  logic [15:0] adr_q;
  logic [15:0] dat_q;
  logic [15:0] rdo_q;
  logic        wr_ok;
  logic        unused_wd;

  assign wr_ok     = wr_en && !busy;
  assign unused_wd = ^wr_data;
  assign rd_data   = rdo_q;

  always_comb begin
    start   = 1'b0;
    kind    = XF_C22_WR;
    port    = port_q;
    regad   = ra_q;
    payload = wr_data;
    if (wr_ok) begin
      case (wr_addr)
        RA_CTL: if (wr_data[CTL_RD_BIT]) begin
          start = 1'b1;
          kind  = mode_q ? XF_C45_RD : XF_C22_RD;
          port  = wr_data[9:5];
          regad = wr_data[4:0];
        end
        RA_ADR: if (mode_q) begin
          start = 1'b1;
          kind  = XF_C45_AD;
        end
        RA_DAT: begin
          start = 1'b1;
          kind  = mode_q ? XF_C45_WR : XF_C22_WR;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      port_q <= '0;
      ra_q   <= '0;
      adr_q  <= '0;
      dat_q  <= '0;
      rdo_q  <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_addr)
          RA_CFG: mode_q <= wr_data[0];
          RA_CTL: begin
            port_q <= wr_data[9:5];
            ra_q   <= wr_data[4:0];
          end
          RA_ADR: adr_q <= wr_data;
          default: dat_q <= wr_data;
        endcase
      end
      if (eng_done) dat_q <= eng_data;
      if (rd_en) begin
        case (rd_addr)
          RA_CFG:  rdo_q <= {13'd0, eng_err, busy, mode_q};
          RA_CTL:  rdo_q <= {6'd0, port_q, ra_q};
          RA_ADR:  rdo_q <= adr_q;
          default: rdo_q <= dat_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic        fall_stb;
  logic        rise_stb;
  logic        eng_busy;
  logic        eng_done;
  logic [15:0] eng_data;
  logic        eng_err;
  logic        start;
  xfer_e       kind;
  logic [4:0]  port;
  logic [4:0]  regad;
  logic [15:0] payload;

  mdio_clkgen #(.DIV(DIV)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb)
  );

  mdio_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .busy     (eng_busy),
    .eng_done (eng_done),
    .eng_data (eng_data),
    .eng_err  (eng_err),
    .start    (start),
    .kind     (kind),
    .port     (port),
    .regad    (regad),
    .payload  (payload)
  );

  mdio_frame_eng u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .kind     (kind),
    .port     (port),
    .regad    (regad),
    .payload  (payload),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (eng_done),
    .rd_data  (eng_data),
    .rd_err   (eng_err)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int DIV = 64
) (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic wr_en
);
  localparam int HALF = DIV / 2;
  localparam int HW   = $clog2(HALF + 1) + 1;

  logic          mdc_d;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_d <= 1'b0;
      hcnt  <= '0;
    end else begin
      mdc_d <= mdc;
      hcnt  <= (mdc != mdc_d) ? HW'(1) : hcnt + 1'b1;
    end
  end

  // R2
  mdc_half_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc != mdc_d) |-> (hcnt == HW'(HALF)));

  // R2
  pin_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe))) |-> $fell(mdc));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
endmodule

bind mdio_mgmt_master mdio_mgmt_chk #(.DIV(DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .busy    (eng_busy),
  .wr_en   (wr_en)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  localparam int DIV = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        mdc;
  logic        mdio_i = 1'b1;
  logic        mdio_o;
  logic        mdio_oe;

  int          vectors = 0;
  int          errors = 0;
  int          frame_cnt = 0;
  int          oe_bad = 0;
  logic [63:0] last_fr = '0;
  logic        phy_present = 1'b1;
  logic [15:0] phy_data = '0;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.DIV(DIV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // PHY responder: records the 64 bits seen at each rising mdc edge
  initial begin
    logic [63:0] fr;
    logic        rd;
    forever begin
      @(posedge mdio_oe);
      fr = '0;
      rd = 1'b0;
      for (int k = 0; k < 64; k++) begin
        if (k >= 46) rd = fr[63-34];
        if (rd && k == 46)      mdio_i = 1'b1;
        else if (rd && k == 47) mdio_i = phy_present ? 1'b0 : 1'b1;
        else if (rd)            mdio_i = phy_present ? phy_data[63-k] : 1'b1;
        else                    mdio_i = 1'b1;
        @(posedge mdc);
        #1;
        fr[63-k] = mdio_o;
        if (rd && mdio_oe) oe_bad++;
        if (!rd && !mdio_oe) oe_bad++;
      end
      mdio_i    = 1'b1;
      last_fr   = fr;
      frame_cnt = frame_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [15:0] c;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(2'd0, c);
      if (!c[1]) break;
    end
  endtask

  function automatic logic [63:0] fr_of(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] r, input logic [1:0] ta, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, p, r, ta, d};
  endfunction

  task automatic t_reset();
    logic [15:0] c;
    check("R1 oe", {63'd0, mdio_oe}, 64'd0);
    check("R1 mdc", {63'd0, mdc}, 64'd0);
    reg_rd(2'd0, c);
    check("R1 cfg", {48'd0, c}, 64'd0);
  endtask

  task automatic t_mdc();
    realtime t0, t1, t2;
    @(posedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    check("R2 period", 64'(int'((t2 - t0) / 4.0)), 64'(DIV));
    check("R2 high", 64'(int'((t1 - t0) / 4.0)), 64'(DIV / 2));
  endtask

  task automatic t_c22_write();
    logic [15:0] c;
    int n0;
    reg_wr(2'd0, 16'h0000);
    reg_wr(2'd1, {6'd0, 5'h11, 5'h0A});
    reg_rd(2'd1, c);
    check("R3 ctl readback", {48'd0, c}, {48'd0, 6'd0, 5'h11, 5'h0A});
    n0 = frame_cnt;
    reg_wr(2'd3, 16'hBEEF);
    reg_rd(2'd0, c);
    check("R10 busy set", {63'd0, c[1]}, 64'd1);
    wait_idle();
    check("R5 frame count", 64'(frame_cnt - n0), 64'd1);
    check("R4 R5 c22 write frame", last_fr, fr_of(2'b01, 2'b01, 5'h11, 5'h0A, 2'b10, 16'hBEEF));
  endtask

  task automatic t_busy_drop();
    logic [15:0] c;
    int n0;
    reg_wr(2'd1, {6'd0, 5'h03, 5'h04});
    n0 = frame_cnt;
    reg_wr(2'd3, 16'h1234);
    reg_wr(2'd1, 16'h83FF);
    reg_wr(2'd3, 16'hFFFF);
    reg_wr(2'd0, 16'h0001);
    wait_idle();
    repeat (200) @(negedge clk);
    check("R10 dropped start", 64'(frame_cnt - n0), 64'd1);
    check("R10 frame intact", last_fr, fr_of(2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h1234));
    reg_rd(2'd0, c);
    check("R10 mode kept", {63'd0, c[0]}, 64'd0);
    reg_rd(2'd1, c);
    check("R10 ctl kept", {48'd0, c}, {48'd0, 6'd0, 5'h03, 5'h04});
  endtask

  task automatic t_c22_read();
    logic [15:0] c;
    phy_present = 1'b1;
    phy_data = 16'hA5C3;
    oe_bad = 0;
    reg_wr(2'd1, 16'h8000 | {6'd0, 5'h02, 5'h01});
    wait_idle();
    check("R6 c22 read header", last_fr >> 18,
          fr_of(2'b01, 2'b10, 5'h02, 5'h01, 2'b00, 16'h0) >> 18);
    check("R2 R6 pin release", 64'(oe_bad), 64'd0);
    reg_rd(2'd0, c);
    check("R7 no error", {63'd0, c[2]}, 64'd0);
    reg_rd(2'd3, c);
    check("R6 read data", {48'd0, c}, 64'hA5C3);
    phy_present = 1'b0;
    reg_wr(2'd1, 16'h8000 | {6'd0, 5'h09, 5'h1F});
    wait_idle();
    reg_rd(2'd0, c);
    check("R7 error set", {63'd0, c[2]}, 64'd1);
    phy_present = 1'b1;
    phy_data = 16'h0001;
    reg_wr(2'd1, 16'h8000 | {6'd0, 5'h09, 5'h1F});
    wait_idle();
    reg_rd(2'd0, c);
    check("R7 error cleared", {63'd0, c[2]}, 64'd0);
    reg_rd(2'd3, c);
    check("R6 read data lsb", {48'd0, c}, 64'h0001);
  endtask

  task automatic t_c22_addr_noop();
    logic [15:0] c;
    int n0;
    reg_wr(2'd0, 16'h0000);
    n0 = frame_cnt;
    reg_wr(2'd2, 16'h5555);
    reg_rd(2'd0, c);
    check("R8 c22 addr no busy", {63'd0, c[1]}, 64'd0);
    repeat (300) @(negedge clk);
    check("R8 c22 addr no frame", 64'(frame_cnt - n0), 64'd0);
    reg_rd(2'd2, c);
    check("R3 addr readback", {48'd0, c}, 64'h5555);
  endtask

  task automatic t_c45();
    logic [15:0] c;
    int n0;
    reg_wr(2'd0, 16'h0001);
    n0 = frame_cnt;
    reg_wr(2'd1, {6'd0, 5'h07, 5'h03});
    repeat (300) @(negedge clk);
    check("R8 ctl no frame", 64'(frame_cnt - n0), 64'd0);
    reg_wr(2'd2, 16'h8001);
    wait_idle();
    check("R8 c45 addr frame", last_fr, fr_of(2'b00, 2'b00, 5'h07, 5'h03, 2'b10, 16'h8001));
    reg_wr(2'd3, 16'h0F0F);
    wait_idle();
    check("R9 c45 write frame", last_fr, fr_of(2'b00, 2'b01, 5'h07, 5'h03, 2'b10, 16'h0F0F));
    phy_data = 16'h3C5A;
    oe_bad = 0;
    reg_wr(2'd1, 16'h8000 | {6'd0, 5'h07, 5'h03});
    wait_idle();
    check("R6 c45 read header", last_fr >> 18,
          fr_of(2'b00, 2'b11, 5'h07, 5'h03, 2'b00, 16'h0) >> 18);
    check("R6 c45 pin release", 64'(oe_bad), 64'd0);
    reg_rd(2'd3, c);
    check("R6 c45 read data", {48'd0, c}, 64'h3C5A);
    check("R4 total frames", 64'(frame_cnt - n0), 64'd3);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mdc();
    t_c22_write();
    t_busy_drop();
    t_c22_read();
    t_c22_addr_noop();
    t_c45();
    finish_run();
  end
endmodule